// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block computes the effective byte address of a memory operand for a small 8-bit processor whose three 16-bit pointers are kept as register pairs in its register file. A request carries the decoded addressing mode, the pointer select, the immediate fields, an optional page byte and a snapshot of the six pointer bytes. The result carries the effective address, a byte-select bit for program-memory constant reads, the pointer write-back value with its enable, and an error flag for illegal pointer use.

Requests enter on a valid/ready channel, and results leave on another valid/ready channel through one register stage. A request is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low with a result pending, that result stays frozen and new requests are refused.

Top module: `ptr_addr_gen`

## Requirements
- R1: The pointer bytes arrive on `in_regs`, with register 26+k in bits [8k+7:8k]. Pointer select 0, 1 and 2 form the pointers {r27,r26}, {r29,r28} and {r31,r30}, with the odd register as the high byte. Mode 0 (plain indirect) outputs the pointer as the address.
- R2: Mode 1 (pre-decrement) outputs pointer minus one as the address, and also as the write-back value.
- R3: Mode 2 (post-increment) outputs the unmodified pointer as the address and writes back pointer plus one.
- R4: Mode 3 (displacement) adds the 6-bit unsigned `in_disp` to pointer 1 or 2 and does not write back. With pointer select 0, the result is an error.
- R5: Mode 4 (direct) outputs the 16-bit `in_imm` as the address, whatever the pointer select.
- R6: Mode 5 (I/O direct) outputs `in_io` + 0x20, which lies in the data-space range 0x20..0x5F, whatever the pointer select.
- R7: Mode 6 (constant fetch) outputs the word address pointer[15:1] and sets `out_byte_hi` to pointer bit 0. Mode 7 does the same and writes back pointer plus one. `out_byte_hi` is 0 in modes 0 to 5.
- R8: In modes 6 and 7 with `in_ext` set, the word address is {`in_page`, pointer[15:1]}. `in_ext` and `in_page` have no effect in modes 0 to 5.
- R9: All pointer arithmetic wraps modulo 2^16: 0x0000 pre-decrements to 0xFFFF, 0xFFFF post-increments to 0x0000, and a displacement sum wraps.
- R10: `out_wb_en` is 1 only in modes 1, 2 and 7. When it is 0, `out_wb_val` is 0. `out_wb_sel` always equals the request's pointer select.
- R11: Pointer select 3 in a pointer-using mode (0, 1, 2, 3, 6, 7) sets `out_err`. The same happens for select 0 in mode 3. In either case the address, byte select and write-back enable are all 0.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1. `in_ready` equals `!out_valid || out_ready`. A pending result holds every output field stable while `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_mode | input | 3 | Addressing mode code (0..7) |
| in_sel | input | 2 | Pointer select |
| in_ext | input | 1 | Extend constant-fetch address with page byte |
| in_disp | input | 6 | Unsigned displacement |
| in_io | input | 6 | I/O-direct address |
| in_imm | input | 16 | Direct data address |
| in_page | input | 8 | Page byte for extended constant fetch |
| in_regs | input | 48 | Pointer register bytes r26..r31 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready for result |
| out_addr | output | 24 | Effective byte or word address |
| out_byte_hi | output | 1 | High byte of program word selected |
| out_wb_en | output | 1 | Pointer write-back enable |
| out_wb_sel | output | 2 | Pointer to write back |
| out_wb_val | output | 16 | Pointer write-back value |
| out_err | output | 1 | Illegal pointer use |

## Verification
The hardest situations to reach from the ports are the arithmetic wrap edges, and a new request colliding with a result still stalled at the output. Uniform random pointer bytes almost never give 0x0000 or 0xFFFF, so the random stimulus forces those values on a fraction of requests, alongside directed cases. The collision case is driven on purpose: `out_ready` is held low, a second request is offered during the stall, and the bench checks that it is refused and then taken on the same edge the first result drains.

// File: rtl/pag_pkg.sv
package pag_pkg;

  typedef enum logic [2:0] {
    M_IND      = 3'd0,
    M_PREDEC   = 3'd1,
    M_POSTINC  = 3'd2,
    M_DISP     = 3'd3,
    M_DIRECT   = 3'd4,
    M_IODIR    = 3'd5,
    M_CONST    = 3'd6,
    M_CONSTINC = 3'd7
  } pag_mode_e;

endpackage

// File: rtl/pag_ptr_bank.sv
module pag_ptr_bank #(
  parameter int BYTE_W = 8,
  parameter int NPTR   = 3,
  parameter int SEL_W  = 2,
  parameter int PTR_W  = 2 * BYTE_W,
  parameter int REG_W  = 2 * NPTR * BYTE_W
) (
  input  logic [REG_W-1:0] regs,
  input  logic [SEL_W-1:0] sel,
  output logic [PTR_W-1:0] ptr,
  output logic             ptr_ok
);

  logic [PTR_W-1:0] pairs [NPTR];

  // Each pointer joins an even (low) and odd (high) register byte.
  for (genvar g = 0; g < NPTR; g++) begin : g_pair
    assign pairs[g] = {regs[(2*g+1)*BYTE_W +: BYTE_W], regs[(2*g)*BYTE_W +: BYTE_W]};
  end

  always_comb begin
    ptr    = '0;
    ptr_ok = 1'b0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SEL_W'(i)) begin
        ptr    = pairs[i];
        ptr_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pag_calc.sv
module pag_calc
  import pag_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int DISP_W  = 6,
  parameter int IO_W    = 6,
  parameter int SEL_W   = 2,
  parameter int IO_BASE = 32,
  parameter int ADDR_W  = PAGE_W + PTR_W
) (
  input  logic [2:0]        mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic              ext,
  input  logic [DISP_W-1:0] disp,
  input  logic [IO_W-1:0]   io,
  input  logic [PTR_W-1:0]  imm,
  input  logic [PAGE_W-1:0] page,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              ptr_ok,
  output logic [ADDR_W-1:0] addr,
  output logic              byte_hi,
  output logic              wb_en,
  output logic [PTR_W-1:0]  wb_val,
  output logic              err
);

  localparam int WADDR_W = ADDR_W - 1;

  pag_mode_e          m;
  logic [PTR_W-1:0]   p_dec, p_inc, p_disp;
  logic [WADDR_W-1:0] waddr;
  logic               uses_ptr;
  logic               disp_bad;

  assign m      = pag_mode_e'(mode);
  assign p_dec  = ptr - PTR_W'(1);
  assign p_inc  = ptr + PTR_W'(1);
  assign p_disp = ptr + PTR_W'(disp);
  assign waddr  = ext ? {page, ptr[PTR_W-1:1]} : {{PAGE_W{1'b0}}, ptr[PTR_W-1:1]};

  always_comb begin
    addr     = '0;
    byte_hi  = 1'b0;
    wb_en    = 1'b0;
    wb_val   = '0;
    uses_ptr = 1'b1;
    disp_bad = 1'b0;
    unique case (m)
      M_IND: addr = ADDR_W'(ptr);
      M_PREDEC: begin
        addr   = ADDR_W'(p_dec);
        wb_en  = 1'b1;
        wb_val = p_dec;
      end
      M_POSTINC: begin
        addr   = ADDR_W'(ptr);
        wb_en  = 1'b1;
        wb_val = p_inc;
      end
      M_DISP: begin
        addr     = ADDR_W'(p_disp);
        disp_bad = (sel == '0);
      end
      M_DIRECT: begin
        addr     = ADDR_W'(imm);
        uses_ptr = 1'b0;
      end
      M_IODIR: begin
        addr     = ADDR_W'(IO_BASE) + ADDR_W'(io);
        uses_ptr = 1'b0;
      end
      M_CONST: begin
        addr    = ADDR_W'(waddr);
        byte_hi = ptr[0];
      end
      M_CONSTINC: begin
        addr    = ADDR_W'(waddr);
        byte_hi = ptr[0];
        wb_en   = 1'b1;
        wb_val  = p_inc;
      end
      default: addr = '0;
    endcase
    err = (uses_ptr && !ptr_ok) || disp_bad;
    if (err) begin
      addr    = '0;
      byte_hi = 1'b0;
      wb_en   = 1'b0;
      wb_val  = '0;
    end
  end

endmodule

// File: rtl/pag_hold.sv
module pag_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int BYTE_W  = 8,
  parameter int NPTR    = 3,
  parameter int PAGE_W  = 8,
  parameter int DISP_W  = 6,
  parameter int IO_W    = 6,
  parameter int IO_BASE = 32,
  localparam int PTR_W  = 2 * BYTE_W,
  localparam int ADDR_W = PAGE_W + PTR_W,
  localparam int SEL_W  = $clog2(NPTR + 1),
  localparam int REG_W  = 2 * NPTR * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic              in_ext,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [IO_W-1:0]   in_io,
  input  logic [PTR_W-1:0]  in_imm,
  input  logic [PAGE_W-1:0] in_page,
  input  logic [REG_W-1:0]  in_regs,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_byte_hi,
  output logic              out_wb_en,
  output logic [SEL_W-1:0]  out_wb_sel,
  output logic [PTR_W-1:0]  out_wb_val,
  output logic              out_err
);

  localparam int PAY_W = ADDR_W + PTR_W + SEL_W + 3;

  logic [PTR_W-1:0]  ptr;
  logic              ptr_ok;
  logic [ADDR_W-1:0] c_addr;
  logic              c_byte_hi, c_wb_en, c_err;
  logic [PTR_W-1:0]  c_wb_val;
  logic [PAY_W-1:0]  pay_in, pay_out;

  pag_ptr_bank #(
    .BYTE_W(BYTE_W), .NPTR(NPTR), .SEL_W(SEL_W)
  ) u_bank (
    .regs   (in_regs),
    .sel    (in_sel),
    .ptr    (ptr),
    .ptr_ok (ptr_ok)
  );

  pag_calc #(
    .PTR_W(PTR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W), .IO_W(IO_W),
    .SEL_W(SEL_W), .IO_BASE(IO_BASE), .ADDR_W(ADDR_W)
  ) u_calc (
    .mode    (in_mode),
    .sel     (in_sel),
    .ext     (in_ext),
    .disp    (in_disp),
    .io      (in_io),
    .imm     (in_imm),
    .page    (in_page),
    .ptr     (ptr),
    .ptr_ok  (ptr_ok),
    .addr    (c_addr),
    .byte_hi (c_byte_hi),
    .wb_en   (c_wb_en),
    .wb_val  (c_wb_val),
    .err     (c_err)
  );

  assign pay_in = {c_addr, c_byte_hi, c_wb_en, in_sel, c_wb_val, c_err};

  pag_hold #(.W(PAY_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_addr, out_byte_hi, out_wb_en, out_wb_sel, out_wb_val, out_err} = pay_out;

endmodule

// File: rtl/pag_chk.sv
module pag_chk #(
  parameter int PTR_W   = 16,
  parameter int ADDR_W  = 24,
  parameter int SEL_W   = 2,
  parameter int IO_BASE = 32,
  parameter int IO_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_mode,
  input logic [SEL_W-1:0]  in_sel,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_byte_hi,
  input logic              out_wb_en,
  input logic [PTR_W-1:0]  out_wb_val,
  input logic              out_err
);

  logic take;
  assign take = in_valid && in_ready;

  // R2
  predec_addr_is_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 3'd1 && in_sel != '1 |=> out_wb_en && out_addr == ADDR_W'(out_wb_val));

  // R3
  postinc_wb_is_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 3'd2 && in_sel != '1 |=> out_wb_en && out_wb_val == out_addr[PTR_W-1:0] + PTR_W'(1));

  // R6
  io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode == 3'd5 |=> !out_err && out_addr >= ADDR_W'(IO_BASE)
      && out_addr < ADDR_W'(IO_BASE + (1 << IO_W)));

  // R7
  data_mode_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode < 3'd6 |=> !out_byte_hi);

  // R10
  no_wb_other_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_mode != 3'd1 && in_mode != 3'd2 && in_mode != 3'd7 |=> !out_wb_en && out_wb_val == '0);

  // R12
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_wb_val)
      && $stable(out_err) && $stable(out_wb_en));

endmodule

bind ptr_addr_gen pag_chk #(
  .PTR_W(PTR_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IO_BASE(IO_BASE), .IO_W(IO_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_mode     (in_mode),
  .in_sel      (in_sel),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_byte_hi (out_byte_hi),
  .out_wb_en   (out_wb_en),
  .out_wb_val  (out_wb_val),
  .out_err     (out_err)
);

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [1:0]  in_sel = '0;
  logic        in_ext = 1'b0;
  logic [5:0]  in_disp = '0;
  logic [5:0]  in_io = '0;
  logic [15:0] in_imm = '0;
  logic [7:0]  in_page = '0;
  logic [47:0] in_regs = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_addr;
  logic        out_byte_hi;
  logic        out_wb_en;
  logic [1:0]  out_wb_sel;
  logic [15:0] out_wb_val;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_sel(in_sel), .in_ext(in_ext), .in_disp(in_disp),
    .in_io(in_io), .in_imm(in_imm), .in_page(in_page), .in_regs(in_regs),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_byte_hi(out_byte_hi), .out_wb_en(out_wb_en), .out_wb_sel(out_wb_sel),
    .out_wb_val(out_wb_val), .out_err(out_err)
  );

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Expected result from the requirement text.
  function automatic logic [42:0] model(input logic [2:0] m, input logic [1:0] s,
      input logic e, input logic [5:0] d, input logic [5:0] io, input logic [15:0] imm,
      input logic [7:0] pg, input logic [47:0] regs);
    logic [15:0] p;
    logic [23:0] a;
    logic bh, we, er, needp;
    logic [15:0] wv;
    case (s)
      2'd0: p = {regs[15:8], regs[7:0]};
      2'd1: p = {regs[31:24], regs[23:16]};
      2'd2: p = {regs[47:40], regs[39:32]};
      default: p = 16'h0;
    endcase
    a = 0; bh = 0; we = 0; wv = 0; er = 0;
    needp = !(m == 3'd4 || m == 3'd5);
    case (m)
      3'd0: a = {8'h0, p};
      3'd1: begin a = {8'h0, p - 16'd1}; we = 1; wv = p - 16'd1; end
      3'd2: begin a = {8'h0, p}; we = 1; wv = p + 16'd1; end
      3'd3: begin a = {8'h0, p + {10'h0, d}}; if (s == 2'd0) er = 1; end
      3'd4: a = {8'h0, imm};
      3'd5: a = 24'h20 + {18'h0, io};
      default: begin
        a = e ? {1'b0, pg, p[15:1]} : {9'h0, p[15:1]};
        bh = p[0];
        if (m == 3'd7) begin we = 1; wv = p + 16'd1; end
      end
    endcase
    if (needp && s == 2'd3) er = 1;
    if (er) begin a = 0; bh = 0; we = 0; wv = 0; end
    return {a, bh, we, s, wv, er};
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Offer one request; it is taken on the next edge and checked at the following negedge.
  task automatic xact(input logic [2:0] m, input logic [1:0] s, input logic e,
      input logic [5:0] d, input logic [5:0] io, input logic [15:0] imm,
      input logic [7:0] pg, input logic [47:0] regs, input string req);
    logic [42:0] exp, act;
    @(negedge clk);
    in_mode = m; in_sel = s; in_ext = e; in_disp = d; in_io = io;
    in_imm = imm; in_page = pg; in_regs = regs; in_valid = 1'b1; out_ready = 1'b1;
    exp = model(m, s, e, d, io, imm, pg, regs);
    @(negedge clk);
    in_valid = 1'b0;
    act = {out_addr, out_byte_hi, out_wb_en, out_wb_sel, out_wb_val, out_err};
    check(out_valid && act == exp, (req == "") ? tag_of(m) : req,
          $sformatf("mode %0d sel %0d", m, s), {20'h0, out_valid, act}, {20'h0, 1'b1, exp});
  endtask

  function automatic logic [47:0] put_ptr(input logic [47:0] regs, input int k,
                                          input logic [15:0] v);
    logic [47:0] r = regs;
    r[k*16 +: 16] = v;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] regs;
    logic [42:0] exp_a, exp_b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!out_valid, "R12", "out_valid in reset", {63'h0, out_valid}, 64'h0);
    check(in_ready, "R12", "in_ready in reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R12", "idle after reset",
          {62'h0, out_valid, in_ready}, 64'h1);

    // R1 pointer pairs
    regs = 48'hF1E0_3C2B_1A09;
    xact(3'd0, 2'd0, 0, 0, 0, 0, 0, regs, "R1");
    xact(3'd0, 2'd1, 0, 0, 0, 0, 0, regs, "R1");
    xact(3'd0, 2'd2, 0, 0, 0, 0, 0, regs, "R1");
    // R2, R3, R9 wrap edges
    xact(3'd1, 2'd2, 0, 0, 0, 0, 0, put_ptr(regs, 2, 16'h0000), "R9");
    xact(3'd2, 2'd0, 0, 0, 0, 0, 0, put_ptr(regs, 0, 16'hFFFF), "R9");
    xact(3'd1, 2'd1, 0, 0, 0, 0, 0, regs, "R2");
    xact(3'd2, 2'd1, 0, 0, 0, 0, 0, regs, "R3");
    // R4 displacement, wrap, illegal pointer 0
    xact(3'd3, 2'd1, 0, 6'd63, 0, 0, 0, regs, "R4");
    xact(3'd3, 2'd2, 0, 6'd40, 0, 0, 0, put_ptr(regs, 2, 16'hFFF0), "R9");
    xact(3'd3, 2'd0, 0, 6'd5, 0, 0, 0, regs, "R4");
    // R5, R6 ignore select
    xact(3'd4, 2'd3, 0, 0, 0, 16'hBEEF, 0, regs, "R5");
    xact(3'd5, 2'd3, 0, 0, 6'd0, 0, 0, regs, "R6");
    xact(3'd5, 2'd0, 0, 0, 6'd63, 0, 0, regs, "R6");
    // R7, R8 constant fetch
    xact(3'd6, 2'd2, 0, 0, 0, 0, 8'hA5, put_ptr(regs, 2, 16'h1235), "R7");
    xact(3'd6, 2'd2, 1, 0, 0, 0, 8'hA5, put_ptr(regs, 2, 16'h1234), "R8");
    xact(3'd7, 2'd2, 1, 0, 0, 0, 8'h7F, put_ptr(regs, 2, 16'hFFFF), "R8");
    xact(3'd0, 2'd1, 1, 0, 0, 0, 8'hFF, regs, "R8");
    xact(3'd2, 2'd1, 1, 0, 0, 0, 8'hFF, regs, "R8");
    // R10, R11 illegal select
    xact(3'd1, 2'd3, 0, 0, 0, 0, 0, regs, "R11");
    xact(3'd7, 2'd3, 1, 0, 0, 0, 8'h11, regs, "R11");
    xact(3'd0, 2'd2, 0, 0, 0, 0, 0, regs, "R10");

    // R12 back-pressure: stall A, offer B, then drain A and take B together.
    @(negedge clk);
    regs = 48'h0102_0304_0506;
    exp_a = model(3'd2, 2'd0, 0, 0, 0, 0, 0, regs);
    exp_b = model(3'd1, 2'd1, 0, 0, 0, 0, 0, regs);
    out_ready = 1'b0;
    in_mode = 3'd2; in_sel = 2'd0; in_ext = 0; in_regs = regs; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && !in_ready, "R12", "stalled refuses input",
          {62'h0, out_valid, in_ready}, 64'h2);
    in_mode = 3'd1; in_sel = 2'd1;
    @(negedge clk);
    check({out_addr, out_byte_hi, out_wb_en, out_wb_sel, out_wb_val, out_err} == exp_a,
          "R12", "held during stall",
          {21'h0, out_addr, out_byte_hi, out_wb_en, out_wb_sel, out_wb_val, out_err},
          {21'h0, exp_a});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_addr, out_byte_hi, out_wb_en, out_wb_sel, out_wb_val, out_err} == exp_b,
          "R12", "second taken on drain",
          {20'h0, out_valid, out_addr, out_byte_hi, out_wb_en, out_wb_sel, out_wb_val, out_err},
          {20'h0, 1'b1, exp_b});
    @(negedge clk);
    check(!out_valid, "R12", "empty after drain", {63'h0, out_valid}, 64'h0);

    // Constrained random with forced wrap values.
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      logic [1:0] s;
      regs = {$urandom, $urandom};
      m = 3'($urandom_range(0, 7));
      s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) regs = put_ptr(regs, (s == 2'd3) ? 0 : int'(s),
                                                    ($urandom_range(0, 1) == 1) ? 16'hFFFF : 16'h0000);
      xact(m, s, 1'($urandom), 6'($urandom), 6'($urandom), 16'($urandom), 8'($urandom), regs, "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule